// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block is a memory-mapped set of hardware mutual-exclusion flags shared by every master on one register bus. Each flag lives in its own 32-bit word. Reading a flag's word is an atomic test-and-set. The read returns the flag's old value and leaves the flag set. A master that reads 0 therefore owns the lock, and a master that reads 1 must try again later. Writing zero to the word releases the lock.

The bus is a simple single-cycle register port with a byte address, read and write strobes, write data and read data. Read data is registered. It appears in the cycle after the read strobe, and the flag is set on that same clock edge. Two reads of one free lock in consecutive cycles therefore return 0 and then 1.

The number of locks is an elaboration-time parameter (32, 64, 128 or 256). A read-only status word reports that number to software.

Top module: `hwlock_bank`

## Requirements
- R1: A read of an implemented lock word whose flag is clear returns 0 and sets that flag on the same clock edge.
- R2: A read of an implemented lock word whose flag is set returns 1 and leaves the flag set. Back-to-back reads of one free lock return 0 and then 1.
- R3: A write of 0x00000000 to an implemented lock word clears that flag. A later read returns 0.
- R4: A write of any non-zero value to a lock word leaves the flag unchanged.
- R5: A read of byte address 0x14 returns the lock count divided by 32 in bits [27:24]. That value is one-hot: 1, 2, 4 or 8. All other bits read 0.
- R6: Lock i sits at byte address 0x800 + 4*i. Address bits [1:0] are ignored. A read or write of one lock never changes another lock.
- R7: A read anywhere in the lock window (0x800 to 0xBFF) beyond the last implemented lock returns 1 and sets no flag.
- R8: After reset every flag is clear and the read data is 0.
- R9: Read data is 0 in every cycle that does not follow a read. A read of any address outside the lock window other than 0x14 returns 0 and has no effect.
- R10: When read and write strobes are both high in one cycle, only the read takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address |
| busRead | input | 1 | Read strobe; a read of a lock word performs the test-and-set |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data, valid the cycle after busRead |

## Verification
The bench reads the same lock on consecutive cycles. A design that sampled the flag after the set, or that set it a cycle late, would return 1 twice or 0 twice. It writes non-zero values to held locks and reads the unused tail of the lock window. A design that treated any write as a release would let a second owner in. A design that decoded the tail as real locks would hand out a phantom lock that reads 0. It also drives read and write strobes together with zero data. If the write were honoured, a lock would be freed behind its owner's back. Finally it checks that reads spread across the whole lock range only ever change the flag that was addressed.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

  // Widest lock index supported (256 locks).
  localparam int MAX_IDX_W = 8;

  // Strobes passed from the decode control to the flag datapath.
  typedef struct packed {
    logic                 rdLock;   // test-and-set read of an implemented lock
    logic                 wrFree;   // release write (zero data) to an implemented lock
    logic                 rdStatus; // read of the lock-count status word
    logic                 rdHole;   // read of an unimplemented slot in the lock window
    logic [MAX_IDX_W-1:0] lockIdx;  // addressed lock number
  } hwlockStrb_t;

  // Status word: lock count / 32 placed at bit 24.
  function automatic logic [31:0] statusWord(input int lockCount);
    logic [31:0] v;
    v = 32'(lockCount / 32);
    return v << 24;
  endfunction

endpackage

// File: rtl/hwlock_ctrl.sv
module hwlock_ctrl
  import hwlock_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int LOCK_COUNT  = 32,
  parameter int LOCK_BASE   = 'h800,
  parameter int STATUS_ADDR = 'h14
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output hwlockStrb_t       strb
);

  localparam int WORD_W       = ADDR_W - 2;
  localparam int WINDOW_WORDS = 256;
  localparam logic [WORD_W-1:0] BASE_WORD   = WORD_W'(LOCK_BASE / 4);
  localparam logic [WORD_W-1:0] STATUS_WORD = WORD_W'(STATUS_ADDR / 4);
  localparam logic [WORD_W:0]   WIN_LIMIT   = (WORD_W+1)'(WINDOW_WORDS);
  localparam logic [WORD_W:0]   LOCK_LIMIT  = (WORD_W+1)'(LOCK_COUNT);

  logic [WORD_W-1:0] wordAddr;
  logic [WORD_W-1:0] offWord;
  logic              inWindow;
  logic              implemented;
  logic              zeroData;

  always_comb begin
    wordAddr    = busAddr[ADDR_W-1:2];
    offWord     = wordAddr - BASE_WORD;
    inWindow    = (wordAddr >= BASE_WORD) && ({1'b0, offWord} < WIN_LIMIT);
    implemented = inWindow && ({1'b0, offWord} < LOCK_LIMIT);
    zeroData    = (busWdata == 32'd0);

    strb.rdLock   = busRead && implemented;
    strb.rdHole   = busRead && inWindow && !implemented;
    strb.rdStatus = busRead && (wordAddr == STATUS_WORD);
    // A read in the same cycle wins; the write is dropped.
    strb.wrFree   = busWrite && !busRead && implemented && zeroData;
    strb.lockIdx  = offWord[MAX_IDX_W-1:0];
  end

endmodule

// File: rtl/hwlock_datapath.sv
module hwlock_datapath
  import hwlock_pkg::*;
#(
  parameter int LOCK_COUNT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  hwlockStrb_t strb,
  output logic [31:0] busRdata
);

  localparam int IDX_W = $clog2(LOCK_COUNT);
  localparam logic [31:0] STATUS_VALUE = statusWord(LOCK_COUNT);

  logic [LOCK_COUNT-1:0] flags;
  logic [LOCK_COUNT-1:0] hitSet;
  logic [LOCK_COUNT-1:0] hitClr;
  logic [IDX_W-1:0]      idx;
  logic                  selFlag;

  assign idx     = strb.lockIdx[IDX_W-1:0];
  assign selFlag = flags[idx];

  // Per-lock one-hot decode of set and clear strobes.
  for (genvar g = 0; g < LOCK_COUNT; g++) begin : g_lock
    assign hitSet[g] = strb.rdLock && (idx == IDX_W'(g));
    assign hitClr[g] = strb.wrFree && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= (flags | hitSet) & ~hitClr;
    end
  end

  // Read data returns the pre-set flag on the same edge that sets it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busRdata <= '0;
    end else if (strb.rdLock) begin
      busRdata <= {31'd0, selFlag};
    end else if (strb.rdHole) begin
      busRdata <= 32'd1;
    end else if (strb.rdStatus) begin
      busRdata <= STATUS_VALUE;
    end else begin
      busRdata <= '0;
    end
  end

endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LOCK_COUNT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);

  hwlockStrb_t strb;

  hwlock_ctrl #(
    .ADDR_W     (ADDR_W),
    .LOCK_COUNT (LOCK_COUNT),
    .LOCK_BASE  ('h800),
    .STATUS_ADDR('h14)
  ) u_ctrl (
    .busAddr (busAddr),
    .busRead (busRead),
    .busWrite(busWrite),
    .busWdata(busWdata),
    .strb    (strb)
  );

  hwlock_datapath #(
    .LOCK_COUNT(LOCK_COUNT)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int ADDR_W     = 12,
  parameter int LOCK_COUNT = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic              busWrite,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata
);

  logic [ADDR_W-3:0] wordAddr;
  logic [ADDR_W-3:0] prevWord;
  logic              isLock;
  logic              isHole;
  logic              isStatus;
  logic              pastValid;
  logic              prevRead;

  always_comb begin
    wordAddr = busAddr[ADDR_W-1:2];
    isLock   = (int'(wordAddr) >= 'h200) && (int'(wordAddr) < 'h200 + LOCK_COUNT);
    isHole   = (int'(wordAddr) >= 'h200 + LOCK_COUNT) && (int'(wordAddr) < 'h300);
    isStatus = (int'(wordAddr) == 'h5);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pastValid <= 1'b0;
      prevRead  <= 1'b0;
      prevWord  <= '0;
    end else begin
      pastValid <= 1'b1;
      prevRead  <= busRead;
      prevWord  <= wordAddr;
    end
  end

  // R1: a lock read returns only 0 or 1
  a_r1_lock_binary: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && isLock) |=> (busRdata[31:1] == 31'd0));

  // R2: second consecutive read of one lock sees it taken
  a_r2_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && prevRead && busRead && isLock && (prevWord == wordAddr))
      |=> (busRdata == 32'd1));

  // R5: status word content
  a_r5_status: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && isStatus) |=> (busRdata == (32'(LOCK_COUNT / 32) << 24)));

  // R5: count field is one-hot
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && isStatus) |=> ($countones(busRdata) == 1));

  // R7: unimplemented window slots read as taken
  a_r7_hole_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && isHole) |=> (busRdata == 32'd1));

  // R9: no read, no data
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!busRead) |=> (busRdata == 32'd0));

endmodule

bind hwlock_bank hwlock_bank_chk #(
  .ADDR_W    (ADDR_W),
  .LOCK_COUNT(LOCK_COUNT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busAddr (busAddr),
  .busRead (busRead),
  .busWrite(busWrite),
  .busWdata(busWdata),
  .busRdata(busRdata)
);

// File: tb/hwlock_bank_bench.sv
`timescale 1ns/1ps
module hwlock_bank_bench;

  localparam int ADDR_W     = 12;
  localparam int LOCK_COUNT = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busRead = 1'b0;
  logic              busWrite = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;

  int checks = 0;
  int errors = 0;

  bit          modelFlags [256];
  logic [31:0] expPrev = 32'd0;
  string       prevTag = "R8";

  always #2.5 clk = ~clk;

  hwlock_bank #(.ADDR_W(ADDR_W), .LOCK_COUNT(LOCK_COUNT)) u_hwlock_bank (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [11:0] lockAddr(input int i);
    return 12'('h800 + 4 * i);
  endfunction

  // Expected behaviour from the requirements; updates the model.
  function automatic logic [31:0] predict(input logic rd, input logic wr,
                                          input logic [11:0] a, input logic [31:0] wd);
    int w;
    logic [31:0] r;
    w = int'(a) / 4;
    r = 32'd0;
    if (rd) begin
      if (w >= 'h200 && w < 'h200 + LOCK_COUNT) begin
        r = {31'd0, modelFlags[w - 'h200]};
        modelFlags[w - 'h200] = 1'b1;
      end else if (w >= 'h200 && w < 'h300) begin
        r = 32'd1;
      end else if (w == 5) begin
        r = 32'(LOCK_COUNT / 32) << 24;
      end
    end else if (wr && wd == 32'd0 && w >= 'h200 && w < 'h200 + LOCK_COUNT) begin
      modelFlags[w - 'h200] = 1'b0;
    end
    return r;
  endfunction

  task automatic checkOut();
    checks++;
    if (busRdata !== expPrev) begin
      errors++;
      $display("FAIL %s: busRdata=%h expected=%h", prevTag, busRdata, expPrev);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [11:0] a,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    checkOut();
    busRead  = rd;
    busWrite = wr;
    busAddr  = a;
    busWdata = wd;
    expPrev  = predict(rd, wr, a, wd);
    prevTag  = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) modelFlags[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: idle after reset reads 0
    step(1'b0, 1'b0, 12'h000, 32'd0, "R8 idle after reset");

    // R8/R1: every lock free after reset; first read claims it
    for (int i = 0; i < LOCK_COUNT; i++) step(1'b1, 1'b0, lockAddr(i), 32'd0, "R1/R8 first read");
    // R2: every lock now reads taken
    for (int i = 0; i < LOCK_COUNT; i++) step(1'b1, 1'b0, lockAddr(i), 32'd0, "R2 held read");
    // R3: release lock 5, then back-to-back reads give 0 then 1
    step(1'b0, 1'b1, lockAddr(5), 32'd0, "R3 release");
    step(1'b1, 1'b0, lockAddr(5), 32'd0, "R3 read after release");
    step(1'b1, 1'b0, lockAddr(5), 32'd0, "R2 back-to-back second");
    // R4: non-zero writes keep lock held
    step(1'b0, 1'b1, lockAddr(7), 32'h1, "R4 write one");
    step(1'b0, 1'b1, lockAddr(7), 32'h8000_0000, "R4 write msb");
    step(1'b1, 1'b0, lockAddr(7), 32'd0, "R4 still held");
    // R6: low address bits ignored, neighbours untouched
    step(1'b0, 1'b1, lockAddr(9) | 12'h3, 32'd0, "R6 release unaligned");
    step(1'b1, 1'b0, lockAddr(8), 32'd0, "R6 neighbour below held");
    step(1'b1, 1'b0, lockAddr(10), 32'd0, "R6 neighbour above held");
    step(1'b1, 1'b0, lockAddr(9) | 12'h2, 32'd0, "R6 unaligned claim");
    // R10: simultaneous read and zero write: write dropped
    step(1'b1, 1'b1, lockAddr(9), 32'd0, "R10 read wins");
    step(1'b1, 1'b0, lockAddr(9), 32'd0, "R10 still held");
    // R5: status word
    step(1'b1, 1'b0, 12'h014, 32'd0, "R5 status");
    step(1'b1, 1'b0, 12'h017, 32'd0, "R5 status unaligned");
    // R7: hole reads 1, no phantom lock
    step(1'b1, 1'b0, lockAddr(LOCK_COUNT), 32'd0, "R7 first hole");
    step(1'b0, 1'b1, lockAddr(LOCK_COUNT), 32'd0, "R7 hole write");
    step(1'b1, 1'b0, lockAddr(LOCK_COUNT), 32'd0, "R7 hole reread");
    step(1'b1, 1'b0, 12'hBFC, 32'd0, "R7 last window word");
    // R9: other addresses read 0; address past window reads 0
    step(1'b1, 1'b0, 12'hC00, 32'd0, "R9 past window");
    step(1'b1, 1'b0, 12'h010, 32'd0, "R9 other register");
    step(1'b1, 1'b0, 12'h7FC, 32'd0, "R9 below window");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int sel, op, li;
      logic [11:0] a;
      logic [31:0] wd;
      logic rd, wr;
      sel = int'($urandom % 10);
      li  = int'($urandom % 6);
      if (sel < 6)       a = lockAddr((li < 4) ? li : LOCK_COUNT - 6 + li);
      else if (sel == 6) a = lockAddr(LOCK_COUNT + int'($urandom % (256 - LOCK_COUNT)));
      else if (sel == 7) a = 12'h014;
      else if (sel == 8) a = 12'($urandom % 'h800);
      else               a = lockAddr(int'($urandom % LOCK_COUNT));
      a  = a | 12'($urandom % 4);
      op = int'($urandom % 20);
      rd = (op < 10) || (op == 19);
      wr = (op >= 10 && op < 18) || (op == 19);
      wd = (($urandom % 10) < 7) ? 32'd0 : $urandom;
      step(rd, wr, a, wd, "R1/R2/R3/R4/R6/R10 random");
    end
    step(1'b0, 1'b0, 12'h000, 32'd0, "R9 idle flush");
    step(1'b0, 1'b0, 12'h000, 32'd0, "R9 idle final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule